// File: doc/BRIEF.md
# SPI Flash Byte Access Port

This block gives software byte-level control of an external serial flash over SPI. One 32-bit register, decoded at a fixed bus address, carries a chip-select request, a start bit, a ready flag and an 8-bit data field. Software sets the select bit, loads a byte together with the start bit, and polls until ready returns. It then reads the byte that was clocked in from the flash, which now sits in the same field. Command sequences for the flash, such as write enable, program, erase and status polling, are built by software from these single-byte exchanges. The select pin is held for as long as software leaves the bit set, so one selection can cover any number of bytes.

The shift engine runs SPI mode 0. The serial clock idles low, the outgoing bit changes when the clock falls, and the incoming bit is captured when it rises. Bits go out and come in most significant first. A parameter sets the serial clock period as an even number of system clocks.

Top module: `spi_byte_port`

## Requirements
- R1: After reset the register reads select 0, start 0, data 0x00 and ready 1. The select pin is high and the serial clock is low.
- R2: The register answers only at address BLOCK_BASE + REG_OFFSET (default 0x080 + 0x010 = 0x090). A write to any other address changes nothing, and a read of any other address returns zero.
- R3: Bit 10 is the select request. The cycle after a write of 1 the select pin is low, and the cycle after a write of 0 it is high. The bit reads back as written.
- R4: Bit 8 is the start bit. A write with bit 8 = 1 while ready is 1 starts a transfer of the byte written in bits 7..0. Bit 8 always reads 0.
- R5: Ready (bit 9) reads 0 from the cycle after the start is accepted. It stays 0 for exactly 8*CLK_DIV + 1 system clocks and then reads 1 again.
- R6: Each transfer produces exactly 8 serial clock pulses with period CLK_DIV and a high time of CLK_DIV/2, so the clock is high for 4*CLK_DIV cycles in total. Outside a transfer the clock is low.
- R7: The outgoing byte appears on MOSI most significant bit first. MOSI does not change while the serial clock is high.
- R8: MISO is captured on each rising serial clock edge, most significant bit first. The assembled byte is in bits 7..0 when ready returns to 1.
- R9: A start written while ready is 0 is ignored. The running transfer keeps its length and its outgoing byte.
- R10: A write to bits 7..0 while ready is 0 is discarded. The field ends the transfer holding the received byte.
- R11: Bits 31..11 are ignored on write. A write that sets them has the same effect as one that clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| spi_sck | output | 1 | Serial clock to the flash, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Flash select, active low |

## Verification
The bench counts how long ready stays low and checks the count against 8*CLK_DIV + 1. An engine that leaves ready up for one cycle too many or too few, or that ends on the eighth rising edge instead of the eighth falling edge, gives a different count. A bus model of the flash returns bytes with all ones, all zeros and single set bits at each end, so a reversed bit order or a missing or extra sample shows up as a wrong received byte. One transfer has a second start and a new data byte written into it partway through. A design that accepts either would restart, lengthen the transfer or leave the wrong byte in the field. Writes to a neighbouring address and writes with the reserved bits set must leave the select pin and the register unchanged.

// File: rtl/spb_pkg.sv
package spb_pkg;
   localparam int REG_W     = 32;
   localparam int BYTE_W    = 8;
   localparam int FLD_START = 8;
   localparam int FLD_READY = 9;
   localparam int FLD_SEL   = 10;
   localparam int LAST_BIT  = BYTE_W - 1;
endpackage

// File: rtl/spb_sck_tick.sv
module spb_sck_tick #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int HALF  = CLK_DIV / 2;
   localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CNT_W-1:0] cnt;

   assign tick = run && (cnt == CNT_W'(HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spb_shifter.sv
module spb_shifter import spb_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              tick,
   input  logic              miso,
   output logic              busy,
   output logic              sck,
   output logic              mosi,
   output logic              rx_valid,
   output logic [BYTE_W-1:0] rx_byte
);
   localparam int BC_W = $clog2(BYTE_W);

   logic [BYTE_W-1:0] tx_sr;
   logic [BYTE_W-1:0] rx_sr;
   logic [BC_W-1:0]   bit_cnt;
   logic              fin;
   logic              last_fall;

   assign last_fall = busy && !fin && tick && sck && (bit_cnt == BC_W'(LAST_BIT));
   assign rx_valid  = last_fall;
   assign rx_byte   = rx_sr;
   assign mosi      = tx_sr[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         sck     <= 1'b0;
         fin     <= 1'b0;
         bit_cnt <= '0;
         tx_sr   <= '0;
         rx_sr   <= '0;
      end else if (start && !busy) begin
         busy    <= 1'b1;
         sck     <= 1'b0;
         fin     <= 1'b0;
         bit_cnt <= '0;
         tx_sr   <= tx_byte;
      end else if (fin) begin
         busy <= 1'b0;
         fin  <= 1'b0;
      end else if (busy && tick) begin
         if (!sck) begin
            sck   <= 1'b1;
            rx_sr <= {rx_sr[BYTE_W-2:0], miso};
         end else begin
            sck <= 1'b0;
            if (bit_cnt == BC_W'(LAST_BIT)) begin
               fin <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
               tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/spb_regfile.sv
module spb_regfile import spb_pkg::*; #(
   parameter int                ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h090
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [REG_W-1:0]  bus_wdata,
   input  logic              busy,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              start,
   output logic              sel_req,
   output logic [BYTE_W-1:0] tx_byte,
   output logic [REG_W-1:0]  bus_rdata
);
   logic              hit;
   logic              wr;
   logic [BYTE_W-1:0] data_q;
   logic              unused_hi;

   assign hit       = (bus_addr == REG_ADDR);
   assign wr        = bus_we && hit;
   assign start     = wr && bus_wdata[FLD_START] && !busy;
   assign tx_byte   = bus_wdata[BYTE_W-1:0];
   assign unused_hi = ^{bus_wdata[REG_W-1:FLD_SEL+1], bus_wdata[FLD_READY]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_req <= 1'b0;
         data_q  <= '0;
      end else begin
         if (wr)
            sel_req <= bus_wdata[FLD_SEL];
         if (rx_valid)
            data_q <= rx_byte;
         else if (wr && !busy)
            data_q <= bus_wdata[BYTE_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         bus_rdata[FLD_SEL]      = sel_req;
         bus_rdata[FLD_READY]    = !busy;
         bus_rdata[BYTE_W-1:0]   = data_q;
      end
   end
endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port import spb_pkg::*; #(
   parameter int                ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] BLOCK_BASE = 'h080,
   parameter logic [ADDR_W-1:0] REG_OFFSET = 'h010,
   parameter int                CLK_DIV    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs_n
);
   localparam logic [ADDR_W-1:0] REG_ADDR = BLOCK_BASE + REG_OFFSET;

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W too narrow for the register address");
      end
   endgenerate

   logic              xfer_start;
   logic              xfer_busy;
   logic              sel_req;
   logic              tick;
   logic              rx_valid;
   logic [BYTE_W-1:0] tx_byte;
   logic [BYTE_W-1:0] rx_byte;

   spb_regfile #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .busy(xfer_busy), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .start(xfer_start), .sel_req(sel_req),
      .tx_byte(tx_byte), .bus_rdata(bus_rdata)
   );

   spb_sck_tick #(.CLK_DIV(CLK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(xfer_busy), .tick(tick)
   );

   spb_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .start(xfer_start), .tx_byte(tx_byte),
      .tick(tick), .miso(spi_miso), .busy(xfer_busy), .sck(spi_sck),
      .mosi(spi_mosi), .rx_valid(rx_valid), .rx_byte(rx_byte)
   );

   assign spi_cs_n = !sel_req;
endmodule

// File: rtl/spb_checker.sv
module spb_checker #(
   parameter int                ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h090
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [31:0]       bus_wdata,
   input logic              spi_sck,
   input logic              spi_mosi,
   input logic              spi_cs_n,
   input logic              busy
);
   logic       hit_wr;
   logic       accept;
   logic       sck_d;
   logic [3:0] rises;

   assign hit_wr = bus_we && (bus_addr == REG_ADDR);
   assign accept = hit_wr && bus_wdata[8] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         rises <= '0;
      end else begin
         sck_d <= spi_sck;
         if (accept)
            rises <= '0;
         else if (spi_sck && !sck_d)
            rises <= rises + 1'b1;
      end
   end

   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy); // R5
   AST_SEL_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      hit_wr |=> (spi_cs_n == !$past(bus_wdata[10]))); // R3
   AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !spi_sck); // R6
   AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R7
   AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      rises <= 4'd8); // R6
   AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (rises == 4'd8)); // R6
   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_wr && busy) |=> busy); // R9
endmodule

bind spi_byte_port spb_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
   .spi_cs_n(spi_cs_n), .busy(xfer_busy)
);

// File: tb/sim_spi_byte_port.sv
`timescale 1ns/1ps
module sim_spi_byte_port;
   localparam int          ADDR_W = 12;
   localparam logic [11:0] REG_A  = 12'h090;
   localparam int          DIV    = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = REG_A;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        spi_sck, spi_mosi, spi_miso, spi_cs_n;

   always #4 clk = ~clk;

   spi_byte_port #(.ADDR_W(ADDR_W), .BLOCK_BASE(12'h080), .REG_OFFSET(12'h010),
                   .CLK_DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // flash model: shifts out slv_byte MSB first, advancing on each falling clock
   logic [7:0] slv_byte = 8'h00;
   int         slv_idx = 0;
   logic [7:0] mosi_cap = 8'h00;
   int         rise_cnt = 0;

   assign spi_miso = (slv_idx < 8) ? slv_byte[7 - slv_idx] : 1'b0;
   always @(negedge spi_sck) slv_idx = slv_idx + 1;
   always @(posedge spi_sck) begin
      mosi_cap = {mosi_cap[6:0], spi_mosi};
      rise_cnt = rise_cnt + 1;
   end

   function automatic logic [10:0] exp_word(bit sel, bit rdy, logic [7:0] d);
      return {sel, rdy, 1'b0, d};
   endfunction

   function automatic logic [31:0] cmd(bit sel, bit go, logic [7:0] d);
      return {21'd0, sel, 1'b0, go, d};
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = REG_A;
   endtask

   task automatic xfer(logic [7:0] tx, logic [7:0] slv, bit interfere);
      int low, hi, bad, n;
      logic psck, pmosi;
      slv_byte = slv; slv_idx = 0; rise_cnt = 0; mosi_cap = 8'h00;
      wr(REG_A, cmd(1'b1, 1'b1, tx));
      low = 0; hi = 0; bad = 0; n = 0; psck = 1'b0; pmosi = 1'b0;
      while (bus_rdata[9] == 1'b0 && n < 2000) begin
         if (n == 1)
            check(bus_rdata[8] == 1'b0, "R4 start reads 0", {31'd0, bus_rdata[8]}, 0);
         if (spi_sck) hi++;
         if (spi_sck && psck && spi_mosi != pmosi) bad++;
         psck = spi_sck; pmosi = spi_mosi;
         low++; n++;
         if (interfere && n == 3) begin
            bus_we = 1'b1; bus_wdata = cmd(1'b1, 1'b1, ~tx);
         end else begin
            bus_we = 1'b0;
         end
         @(negedge clk);
      end
      bus_we = 1'b0;
      check(low == 8*DIV + 1, interfere ? "R9 ready low length" : "R5 ready low length",
            low, 8*DIV + 1);
      check(rise_cnt == 8, "R6 clock pulse count", rise_cnt, 8);
      check(hi == 4*DIV, "R6 clock high cycles", hi, 4*DIV);
      check(bad == 0 && spi_sck == 1'b0, "R7 mosi stable while clock high", bad, 0);
      check(mosi_cap == tx, interfere ? "R9 outgoing byte" : "R7 outgoing byte",
            {24'd0, mosi_cap}, {24'd0, tx});
      check(bus_rdata[10:0] == exp_word(1'b1, 1'b1, slv),
            interfere ? "R10 received byte kept" : "R8 received byte",
            {21'd0, bus_rdata[10:0]}, {21'd0, exp_word(1'b1, 1'b1, slv)});
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual %0d expected below 150000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7331));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(bus_rdata[10:0] == exp_word(1'b0, 1'b1, 8'h00), "R1 reset register",
            {21'd0, bus_rdata[10:0]}, {21'd0, exp_word(1'b0, 1'b1, 8'h00)});
      check(spi_cs_n == 1'b1, "R1 select pin high", spi_cs_n, 1);
      check(spi_sck == 1'b0, "R1 clock low", spi_sck, 0);

      // R3 select request
      wr(REG_A, cmd(1'b1, 1'b0, 8'h00));
      check(spi_cs_n == 1'b0 && bus_rdata[10] == 1'b1, "R3 select asserted",
            {30'd0, spi_cs_n, bus_rdata[10]}, 32'd1);
      wr(REG_A, cmd(1'b0, 1'b0, 8'h00));
      check(spi_cs_n == 1'b1 && bus_rdata[10] == 1'b0, "R3 select released",
            {30'd0, spi_cs_n, bus_rdata[10]}, 32'd2);

      // R2 other address
      rise_cnt = 0;
      wr(REG_A + 12'h004, cmd(1'b1, 1'b1, 8'h3C));
      repeat (4) @(negedge clk);
      check(bus_rdata[10:0] == exp_word(1'b0, 1'b1, 8'h00) && spi_cs_n && rise_cnt == 0,
            "R2 foreign write ignored", {21'd0, bus_rdata[10:0]},
            {21'd0, exp_word(1'b0, 1'b1, 8'h00)});
      bus_addr = REG_A + 12'h004;
      #1;
      check(bus_rdata == 32'd0, "R2 foreign read zero", bus_rdata, 0);
      bus_addr = REG_A;

      // R11 reserved bits
      wr(REG_A, 32'hFFFF_F800 | 32'h0000_005A);
      repeat (4) @(negedge clk);
      check(bus_rdata[10:0] == exp_word(1'b0, 1'b1, 8'h5A), "R11 reserved ignored",
            {21'd0, bus_rdata[10:0]}, {21'd0, exp_word(1'b0, 1'b1, 8'h5A)});
      check(spi_cs_n == 1'b1 && rise_cnt == 0, "R11 no side effect",
            {31'd0, spi_cs_n}, 1);

      // directed corner bytes
      xfer(8'h00, 8'hFF, 1'b0);
      xfer(8'hFF, 8'h00, 1'b0);
      xfer(8'h80, 8'h01, 1'b0);
      xfer(8'h01, 8'h80, 1'b0);
      // R9 R10 write during transfer
      xfer(8'hA5, 8'h5A, 1'b1);
      // random traffic
      for (int i = 0; i < 24; i++) begin
         logic [7:0] t, s;
         t = 8'($urandom);
         s = 8'($urandom);
         xfer(t, s, ($urandom % 4) == 0);
      end
      wr(REG_A, cmd(1'b0, 1'b0, 8'h00));
      check(spi_cs_n == 1'b1, "R3 final release", spi_cs_n, 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule